// File: doc/BRIEF.md
# Synchronous DRAM Read Path with Precharge Cut-Off

This block is the device-side read data path of a four-bank synchronous DRAM. It takes one decoded command per clock, together with a bank, a column and a latency select. A read starts a four-beat burst. The first beat appears on the data bus a set number of clocks after the read, and the following beats come out on consecutive clocks. The data comes from a small internal register file whose contents are fixed at reset.

A precharge to the bank being read cuts the burst short. Output stops a CAS-latency number of clocks after the precharge, so the number of clocks between the read and the precharge sets how many beats appear. On the clock where the next beat would have appeared, a one-clock truncation flag is raised instead. A precharge to any other bank, or one that comes too late to remove a beat, has no effect on the burst.

Top module: `sdram_rd_trunc`

## Requirements
- R1: While reset is asserted and after it is released, `dq_o` is 0, `dq_vld_o` is 0 and `trunc_o` is 0 until a read produces data.
- R2: `cmd_i` encodes 0 as no-op, 1 as read and 2 as precharge. `cas3_i` is sampled with the read: 0 selects latency 2 and 1 selects latency 3. Counting the clock edge that samples the read as edge E, beat 0 is on the bus just after edge E+latency.
- R3: A burst with no cutting precharge drives exactly 4 valid beats on consecutive clocks. Beat i is just after edge E+latency+i.
- R4: Beat i reads column {col[3:2], (col[1:0]+i) mod 4}. The upper column bits stay fixed, so the address wraps inside an aligned group of 4.
- R5: The word at bank b and column c is ((b*16 + c) XOR 0x5A) truncated to 8 bits.
- R6: Let a precharge to the read's bank be sampled d edges after the read, with 1 ≤ d ≤ 3. Then exactly d beats (beats 0 to d-1) are driven.
- R7: When a burst is cut, `trunc_o` is high for exactly one clock, just after edge E+latency+d. In that clock `dq_vld_o` is low, and the clock before it carried a valid beat.
- R8: A precharge to a bank other than the one being read does not change the burst.
- R9: A same-bank precharge sampled 4 or more edges after the read leaves all 4 beats and raises no truncation flag.
- R10: Whenever `dq_vld_o` is low, `dq_o` is 0.
- R11: A new read sampled while an earlier burst is pending abandons the earlier burst. Beats of the earlier burst that are due at or before the new read's edge still appear. Later ones do not appear, and no truncation flag is raised for them. The new burst then follows R2 to R5.
- R12: If several same-bank precharges arrive during one burst, the earliest one sets the beat count. A later precharge never extends the burst.
- R13: Command code 3 is treated as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 2 | Decoded command: 0 no-op, 1 read, 2 precharge, 3 no-op |
| bank_i | input | 2 | Bank address for read or precharge |
| col_i | input | 4 | Starting column of a read |
| cas3_i | input | 1 | Latency select sampled with a read: 0 = 2 clocks, 1 = 3 clocks |
| dq_o | output | 8 | Read data, 0 when idle |
| dq_vld_o | output | 1 | High while `dq_o` carries a burst beat |
| trunc_o | output | 1 | One-clock pulse where a cut burst would have continued |

## Verification
Beat i of a read sampled at edge E is due just after edge E+latency+i. When a precharge at distance d cuts the burst, the truncation pulse is due just after edge E+latency+d. Each command task notes the edge number that samples its read. From the requirements alone, it works out the exact edge each beat and each pulse belongs to and queues those entries in order. On every falling edge, a monitor holding a running edge count compares the bus against the queue head for that edge, or against the idle value when nothing is due. This means an early or late beat shows up as a mismatch on both of the clocks it affects.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_READ = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;

  localparam int CL_SHORT = 2;
  localparam int CL_LONG  = 3;
  localparam int DLY_W    = $clog2(CL_LONG);

endpackage

// File: rtl/sdram_rd_store.sv
module sdram_rd_store #(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_BANKS)-1:0] rd_bank,
  input  logic [COL_W-1:0]             rd_col,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] cell_q [NUM_BANKS][DEPTH];

  // contents are loaded at reset and then held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int c = 0; c < DEPTH; c++) begin
          cell_q[b][c] <= DATA_W'((b * DEPTH + c) ^ 'h5A);
        end
      end
    end
  end

  assign rd_data = cell_q[rd_bank][rd_col];

endmodule

// File: rtl/sdram_rd_sched.sv
module sdram_rd_sched
  import sdram_rd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  cmd_e                         cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic [COL_W-1:0]             col_i,
  input  logic                         cas3_i,
  output logic                         emit_o,
  output logic                         cut_o,
  output logic [$clog2(NUM_BANKS)-1:0] beat_bank_o,
  output logic [COL_W-1:0]             beat_col_o
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(BURST_LEN + 1);
  localparam int LSB_W  = $clog2(BURST_LEN);
  localparam logic [CNT_W-1:0] BL_C = CNT_W'(BURST_LEN);

  typedef struct packed {
    logic              busy;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [CNT_W-1:0]  beat;
    logic [DLY_W-1:0]  dly;
    logic [CNT_W-1:0]  age;
    logic [CNT_W-1:0]  limit;
  } sched_t;

  sched_t st_q, st_d;
  logic   slot;

  // output slot reached once the latency countdown is exhausted
  assign slot   = st_q.busy && (st_q.dly == '0);
  assign emit_o = slot && (st_q.beat < st_q.limit);
  assign cut_o  = slot && (st_q.beat >= st_q.limit);

  assign beat_bank_o = st_q.bank;
  assign beat_col_o  = {st_q.col[COL_W-1:LSB_W],
                        st_q.col[LSB_W-1:0] + st_q.beat[LSB_W-1:0]};

  always_comb begin
    st_d = st_q;
    if (st_q.busy && st_q.dly != '0) begin
      st_d.dly = st_q.dly - 1'b1;
    end
    if (emit_o) begin
      st_d.beat = st_q.beat + 1'b1;
      if (st_q.beat + 1'b1 == BL_C) begin
        st_d.busy = 1'b0;
      end
    end
    if (cut_o) begin
      st_d.busy = 1'b0;
    end
    if (st_q.busy && st_q.age < BL_C) begin
      st_d.age = st_q.age + 1'b1;
    end
    if (cmd_i == CMD_PRE && st_q.busy && bank_i == st_q.bank) begin
      st_d.limit = (st_q.age < st_q.limit) ? st_q.age : st_q.limit;
    end
    if (cmd_i == CMD_READ) begin
      st_d.busy  = 1'b1;
      st_d.bank  = bank_i;
      st_d.col   = col_i;
      st_d.beat  = '0;
      st_d.dly   = cas3_i ? DLY_W'(CL_LONG - 1) : DLY_W'(CL_SHORT - 1);
      st_d.age   = CNT_W'(1);
      st_d.limit = BL_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  // R12: the beat allowance only shrinks during a burst
  assert_limit_no_grow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.busy && cmd_i != CMD_READ) |=> (st_q.limit <= $past(st_q.limit)));

endmodule

// File: rtl/sdram_rd_out.sv
module sdram_rd_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit_i,
  input  logic              cut_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              vld_o,
  output logic              trunc_o
);

  logic [DATA_W-1:0] dq_d;
  logic              vld_d;
  logic              trunc_d;

  always_comb begin
    dq_d    = emit_i ? data_i : '0;
    vld_d   = emit_i;
    trunc_d = cut_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o    <= '0;
      vld_o   <= 1'b0;
      trunc_o <= 1'b0;
    end else begin
      dq_o    <= dq_d;
      vld_o   <= vld_d;
      trunc_o <= trunc_d;
    end
  end

endmodule

// File: rtl/sdram_rd_trunc.sv
module sdram_rd_trunc
  import sdram_rd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 4,
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic [COL_W-1:0]             col_i,
  input  logic                         cas3_i,
  output logic [DATA_W-1:0]            dq_o,
  output logic                         dq_vld_o,
  output logic                         trunc_o
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  logic              rst_meta_q, rst_s_n;
  logic              emit, cut;
  logic [BANK_W-1:0] beat_bank;
  logic [COL_W-1:0]  beat_col;
  logic [DATA_W-1:0] beat_data;
  cmd_e              cmd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  assign cmd = cmd_e'(cmd_i);

  sdram_rd_sched #(
    .NUM_BANKS (NUM_BANKS),
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .cmd_i       (cmd),
    .bank_i      (bank_i),
    .col_i       (col_i),
    .cas3_i      (cas3_i),
    .emit_o      (emit),
    .cut_o       (cut),
    .beat_bank_o (beat_bank),
    .beat_col_o  (beat_col)
  );

  sdram_rd_store #(
    .NUM_BANKS (NUM_BANKS),
    .COL_W     (COL_W),
    .DATA_W    (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .rd_bank (beat_bank),
    .rd_col  (beat_col),
    .rd_data (beat_data)
  );

  sdram_rd_out #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .emit_i  (emit),
    .cut_i   (cut),
    .data_i  (beat_data),
    .dq_o    (dq_o),
    .vld_o   (dq_vld_o),
    .trunc_o (trunc_o)
  );

  // R2: first beat two clocks after a short-latency read
  assert_first_beat_cl2_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(rst_s_n, 3) && $past(cmd_i == 2'd1 && !cas3_i, 3) &&
     $past(cmd_i != 2'd1, 2) && $past(cmd_i != 2'd1, 1)) |-> dq_vld_o);

  // R2: first beat three clocks after a long-latency read
  assert_first_beat_cl3_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(rst_s_n, 4) && $past(cmd_i == 2'd1 && cas3_i, 4) &&
     $past(cmd_i != 2'd1, 3) && $past(cmd_i != 2'd1, 2) &&
     $past(cmd_i != 2'd1, 1)) |-> dq_vld_o);

  // R7: cut flag lasts one clock
  assert_trunc_single_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    trunc_o |=> !trunc_o);

  // R7: a cut always follows a delivered beat
  assert_trunc_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    trunc_o |-> (!dq_vld_o && $past(dq_vld_o)));

endmodule

// File: tb/test_sdram_rd_trunc.sv
module test_sdram_rd_trunc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [1:0] bank = 2'd0;
  logic [3:0] col = 4'd0;
  logic       cas3 = 1'b0;
  logic [7:0] dq;
  logic       dq_vld;
  logic       trunc;

  sdram_rd_trunc i_sdram_rd_trunc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .bank_i   (bank),
    .col_i    (col),
    .cas3_i   (cas3),
    .dq_o     (dq),
    .dq_vld_o (dq_vld),
    .trunc_o  (trunc)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic       vld;
    logic [7:0] data;
    logic       cut;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;

  function automatic logic [7:0] pat(int b, int c);
    return 8'((b * 16 + c) ^ 'h5A);
  endfunction

  task automatic check(string tag, logic v, logic [7:0] d, logic t,
                       logic ev, logic [7:0] ed, logic et);
    n_cmp++;
    if (v !== ev || d !== ed || t !== et) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual vld=%b dq=%h trunc=%b expected vld=%b dq=%h trunc=%b",
               tag, cyc, v, d, t, ev, ed, et);
    end
  endtask

  // monitor: pops the entry due at this edge, otherwise expects idle (R10)
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      e = '{at: cyc, vld: 1'b0, data: 8'h00, cut: 1'b0, tag: "R10"};
      if (sb.size() > 0 && sb[0].at == cyc) e = sb.pop_front();
      check(e.tag, dq_vld, dq, trunc, e.vld, e.data, e.cut);
    end
  end

  task automatic push(int at, logic v, logic [7:0] d, logic t, string tag);
    sb.push_back('{at: at, vld: v, data: d, cut: t, tag: tag});
  endtask

  // one read, optionally followed by up to two precharges at distances p1, p2
  task automatic burst(int b, int c, bit l3, int p1, int b1, int p2, int b2,
                       bit rsv, string tag);
    int e;
    int lat;
    int n;
    @(negedge clk);
    e = cyc + 1;
    cmd = 2'd1; bank = 2'(b); col = 4'(c); cas3 = l3;
    lat = l3 ? 3 : 2;
    n = 4;
    if (p1 > 0 && p1 < 4 && b1 == b) n = p1;
    if (p2 > 0 && p2 < n && b2 == b) n = p2;
    for (int i = 0; i < n; i++)
      push(e + lat + i, 1'b1, pat(b, (c & 12) | ((c + i) & 3)), 1'b0, tag);
    if (n < 4) push(e + lat + n, 1'b0, 8'h00, 1'b1, "R7");
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == p1) begin cmd = 2'd2; bank = 2'(b1); end
      else if (k == p2) begin cmd = 2'd2; bank = 2'(b2); end
      else cmd = rsv ? 2'd3 : 2'd0;
      cas3 = ~cas3;
    end
    @(negedge clk);
    cmd = 2'd0;
    repeat (3) @(negedge clk);
  endtask

  // R11: second read g edges after the first
  task automatic reread(int ba, int ca, bit la, int bb, int cb, bit lb, int g);
    int e;
    int lat_a;
    int lat_b;
    @(negedge clk);
    e = cyc + 1;
    cmd = 2'd1; bank = 2'(ba); col = 4'(ca); cas3 = la;
    lat_a = la ? 3 : 2;
    lat_b = lb ? 3 : 2;
    for (int i = 0; i < 4; i++)
      if (lat_a + i <= g) push(e + lat_a + i, 1'b1, pat(ba, (ca & 12) | ((ca + i) & 3)), 1'b0, "R11");
    for (int i = 0; i < 4; i++)
      push(e + g + lat_b + i, 1'b1, pat(bb, (cb & 12) | ((cb + i) & 3)), 1'b0, "R11");
    for (int k = 1; k < g; k++) begin
      @(negedge clk);
      cmd = 2'd0;
    end
    @(negedge clk);
    cmd = 2'd1; bank = 2'(bb); col = 4'(cb); cas3 = lb;
    @(negedge clk);
    cmd = 2'd0;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    check("R1", dq_vld, dq, trunc, 1'b0, 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", dq_vld, dq, trunc, 1'b0, 8'h00, 1'b0);
    mon_on = 1'b1;
    burst(1, 0, 1'b0, 0, 0, 0, 0, 1'b0, "R2 R3 R5");
    burst(3, 9, 1'b1, 0, 0, 0, 0, 1'b0, "R2 R3 R5");
    burst(2, 6, 1'b1, 0, 0, 0, 0, 1'b0, "R4");
    burst(0, 15, 1'b0, 0, 0, 0, 0, 1'b0, "R4");
    burst(1, 2, 1'b0, 1, 1, 0, 0, 1'b0, "R6");
    burst(2, 4, 1'b1, 2, 2, 0, 0, 1'b0, "R6");
    burst(3, 7, 1'b0, 3, 3, 0, 0, 1'b0, "R6");
    burst(0, 1, 1'b1, 1, 0, 0, 0, 1'b0, "R6");
    burst(1, 5, 1'b1, 3, 1, 0, 0, 1'b0, "R6");
    burst(2, 8, 1'b0, 1, 3, 2, 1, 1'b0, "R8");
    burst(0, 3, 1'b1, 1, 2, 0, 0, 1'b0, "R8");
    burst(3, 12, 1'b0, 4, 3, 0, 0, 1'b0, "R9");
    burst(1, 10, 1'b1, 5, 1, 0, 0, 1'b0, "R9");
    burst(2, 1, 1'b0, 2, 2, 3, 2, 1'b0, "R12");
    burst(0, 6, 1'b1, 1, 0, 3, 0, 1'b0, "R12");
    burst(3, 2, 1'b0, 0, 0, 0, 0, 1'b1, "R13");
    reread(1, 4, 1'b0, 2, 9, 1'b1, 3);
    reread(3, 0, 1'b1, 0, 14, 1'b0, 1);
    repeat (5) @(negedge clk);
    if (sb.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 actual %0d beats left unseen expected 0", sb.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule